// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Current Regulator Controller

This block is the digital sequencer for one solenoid drive channel. It turns a power switch on and off so that the load current follows a peak-then-hold profile. Each regulation cycle is set by peak current and a fixed off-time. An external comparator reports when the sensed current reaches the threshold that the block has selected. On each report the block opens the switch for a programmed off-time and then closes it again. The comparator is blanked for a short window after every turn-on, so switching transients cannot end an on-phase early.

Four modes set the profile. The first drives the switch straight from the command. The second regulates only at the hold level. The third regulates at the peak level until the current first reaches it and then drops to hold. The fourth regulates at the peak level for a programmed time and then drops to hold. All timing runs on an external microsecond tick. The configuration inputs are captured when the command turns on and are held for the rest of that on period.

Top module: `ph_reg_ctrl`

## Requirements
- R1: Out of reset, gate_en is 0, thr_peak is 0 and thr_sel is 2'b00.
- R2: With mode 2'b00, gate_en rises one clock after cmd_on is first sampled high and stays high until cmd_on falls. cmp_hit has no effect in this mode, thr_peak stays 0 and thr_sel shows the hold code.
- R3: While cmd_on is low, gate_en is low in the same cycle. On the next clock the controller is idle: thr_peak is 0, thr_sel is 2'b00 and all timers are cleared. A later turn-on starts with full blanking and a fresh peak-time window.
- R4: After every switch turn-on, cmp_hit is ignored for BLANK_US ticks (default 20). A hit first acts at the clock edge after the blanking count is used up.
- R5: In the regulating modes, an accepted hit drives gate_en low for exactly 100*(off_code+1) ticks. The gate then turns on again, and this repeats until the command goes off.
- R6: With mode 2'b01, regulation runs at the hold level only: thr_peak stays 0.
- R7: With mode 2'b10, thr_peak is 1 from turn-on until the first accepted hit. From that hit to the end of the on period it is 0.
- R8: With mode 2'b11, thr_peak is 1 for exactly 800+400*pt_code ticks, counted from the command turn-on. The regulator's own off/on cycles do not restart this count. After the count ends, thr_peak is 0 for the rest of the on period.
- R9: All three timers (blanking, off-time, peak-time) advance only on clocks where us_tick is 1.
- R10: mode and the four code inputs are sampled only at command turn-on. Changing them during an on period has no effect until the next turn-on.
- R11: While active, thr_sel equals pk_code when thr_peak is 1 and hd_code when thr_peak is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | External on/off command, high active |
| mode | input | 2 | Regulation mode: 00 direct, 01 hold only, 10 peak until first hit, 11 timed peak |
| pk_code | input | 2 | Peak level code (00..11 = 1.2, 1.8, 2.4, 3.6 A) |
| hd_code | input | 2 | Hold level code (00..11 = 0.7, 1.0, 1.4, 2.0 A) |
| off_code | input | 2 | Fixed off-time code (100, 200, 300, 400 us) |
| pt_code | input | 3 | Peak-time code (0.8 ms to 3.6 ms in 0.4 ms steps) |
| cmp_hit | input | 1 | Comparator: current has reached the selected threshold |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| gate_en | output | 1 | Power switch gate enable |
| thr_peak | output | 1 | 1 when the peak level is the active threshold |
| thr_sel | output | 2 | Level code presented to the threshold DAC |

## Verification
Some properties are checked by assertions on every cycle: the gate is released after a low command, the switch stays closed while blanking runs, the switch stays open while the off-time count runs, the hold phase never goes back to peak within one on period, the captured configuration stays frozen while active, and the timers freeze when no tick arrives. Other behaviour needs the bench's scenarios. These cover the exact on and off durations for every mode and off-time code, the timed peak window for every peak-time code, hits that fall inside the blanking window, a stalled tick, configuration changes in the middle of an on period, and a restart after the command drops during the off phase.

// File: rtl/ph_pkg.sv
package ph_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_HOLD     = 2'b01,
        MODE_PK_MIN   = 2'b10,
        MODE_PK_TIMED = 2'b11
    } ph_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_DRIVE = 2'b01,
        ST_REST  = 2'b10
    } ph_state_e;

    typedef struct packed {
        ph_mode_e    mode;
        logic [1:0]  pk_code;
        logic [1:0]  hd_code;
        logic [1:0]  off_code;
        logic [2:0]  pt_code;
    } ph_cfg_t;

    function automatic int ph_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ph_tick_timer.sv
module ph_tick_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy,
    output logic         expire
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy   = (cnt_q != '0);
    assign expire = tick && !clear && !load && (cnt_q == W'(1));

    // R9: without a tick, and with no load or clear, the count does not move
    a_r9_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clear) |=> $stable(cnt_q));

    // R3: a clear empties the timer
    a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !busy);

endmodule

// File: rtl/ph_seq.sv
module ph_seq
    import ph_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_on,
    input  logic       cmp_hit,
    input  ph_cfg_t    cfg_in,
    input  logic       blank_busy,
    input  logic       off_expire,
    input  logic       pk_expire,
    output ph_cfg_t    cfg_o,
    output logic       drive_o,
    output logic       peak_o,
    output logic [1:0] thr_sel_o,
    output logic       load_blank,
    output logic       load_off,
    output logic       load_pk
);

    typedef struct packed {
        ph_state_e st;
        logic      peak;
        ph_cfg_t   cfg;
    } seq_t;

    seq_t seq_d, seq_q;
    logic hit_ok;

    always_comb begin
        seq_d      = seq_q;
        load_blank = 1'b0;
        load_off   = 1'b0;
        load_pk    = 1'b0;
        hit_ok     = (seq_q.cfg.mode != MODE_DIRECT) && cmp_hit && !blank_busy;

        unique case (seq_q.st)
            ST_IDLE: begin
                if (cmd_on) begin
                    seq_d.st   = ST_DRIVE;
                    seq_d.cfg  = cfg_in;
                    seq_d.peak = (cfg_in.mode == MODE_PK_MIN) ||
                                 (cfg_in.mode == MODE_PK_TIMED);
                    load_blank = 1'b1;
                    load_pk    = (cfg_in.mode == MODE_PK_TIMED);
                end
            end
            ST_DRIVE: begin
                if (hit_ok) begin
                    seq_d.st = ST_REST;
                    load_off = 1'b1;
                    if (seq_q.cfg.mode == MODE_PK_MIN) begin
                        seq_d.peak = 1'b0;
                    end
                end
            end
            ST_REST: begin
                if (off_expire) begin
                    seq_d.st   = ST_DRIVE;
                    load_blank = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (pk_expire && (seq_q.st != ST_IDLE)) begin
            seq_d.peak = 1'b0;
        end

        if (!cmd_on) begin
            seq_d.st   = ST_IDLE;
            seq_d.peak = 1'b0;
            load_blank = 1'b0;
            load_off   = 1'b0;
            load_pk    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, peak: 1'b0, cfg: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cfg_o     = seq_q.cfg;
    assign drive_o   = (seq_q.st == ST_DRIVE);
    assign peak_o    = seq_q.peak;
    assign thr_sel_o = (seq_q.st == ST_IDLE) ? 2'b00 :
                       (seq_q.peak ? seq_q.cfg.pk_code : seq_q.cfg.hd_code);

    // R7/R8: once at hold, the peak level never returns within one on period
    a_r7_hold_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && !seq_q.peak) |=> !seq_q.peak);

    // R10: the captured configuration is frozen while active
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) |=> $stable(seq_q.cfg));

    // R2: direct mode keeps the switch closed while commanded
    a_r2_direct_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DRIVE && seq_q.cfg.mode == MODE_DIRECT && cmd_on)
        |=> (seq_q.st == ST_DRIVE));

    // R6: hold-only and direct modes never select the peak level
    a_r6_no_peak_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE && (seq_q.cfg.mode == MODE_HOLD ||
                                 seq_q.cfg.mode == MODE_DIRECT)) |-> !seq_q.peak);

endmodule

// File: rtl/ph_reg_ctrl.sv
module ph_reg_ctrl
    import ph_pkg::*;
#(
    parameter int BLANK_US    = 20,
    parameter int OFF_STEP_US = 100,
    parameter int PT_BASE_US  = 800,
    parameter int PT_STEP_US  = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_on,
    input  logic [1:0] mode,
    input  logic [1:0] pk_code,
    input  logic [1:0] hd_code,
    input  logic [1:0] off_code,
    input  logic [2:0] pt_code,
    input  logic       cmp_hit,
    input  logic       us_tick,
    output logic       gate_en,
    output logic       thr_peak,
    output logic [1:0] thr_sel
);

    localparam int N_TMR   = 3;
    localparam int T_BLANK = 0;
    localparam int T_OFF   = 1;
    localparam int T_PK    = 2;
    localparam int OFF_MAX = 4 * OFF_STEP_US;
    localparam int PT_MAX  = PT_BASE_US + 7 * PT_STEP_US;
    localparam int TW      = $clog2(ph_max3(BLANK_US, OFF_MAX, PT_MAX) + 1);

    ph_cfg_t          cfg_in, cfg_q;
    logic             drive_q;
    logic             tmr_clear;
    logic [N_TMR-1:0] tmr_load, tmr_busy, tmr_expire;
    logic [TW-1:0]    tmr_val [N_TMR];

    always_comb begin
        cfg_in.mode     = ph_mode_e'(mode);
        cfg_in.pk_code  = pk_code;
        cfg_in.hd_code  = hd_code;
        cfg_in.off_code = off_code;
        cfg_in.pt_code  = pt_code;
    end

    ph_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_on     (cmd_on),
        .cmp_hit    (cmp_hit),
        .cfg_in     (cfg_in),
        .blank_busy (tmr_busy[T_BLANK]),
        .off_expire (tmr_expire[T_OFF]),
        .pk_expire  (tmr_expire[T_PK]),
        .cfg_o      (cfg_q),
        .drive_o    (drive_q),
        .peak_o     (thr_peak),
        .thr_sel_o  (thr_sel),
        .load_blank (tmr_load[T_BLANK]),
        .load_off   (tmr_load[T_OFF]),
        .load_pk    (tmr_load[T_PK])
    );

    assign tmr_clear = !cmd_on;

    always_comb begin
        tmr_val[T_BLANK] = TW'(BLANK_US);
        tmr_val[T_OFF]   = TW'(OFF_STEP_US * (int'(cfg_q.off_code) + 1));
        tmr_val[T_PK]    = TW'(PT_BASE_US + PT_STEP_US * int'(cfg_in.pt_code));
    end

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        ph_tick_timer #(.W(TW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (us_tick),
            .clear    (tmr_clear),
            .load     (tmr_load[gi]),
            .load_val (tmr_val[gi]),
            .busy     (tmr_busy[gi]),
            .expire   (tmr_expire[gi])
        );
    end

    assign gate_en = drive_q && cmd_on;

    // R3: a low command leaves the sequencer with the switch open
    a_r3_idle_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_on |=> !drive_q);

    // R3: a low command empties the peak-time window
    a_r3_peak_window_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_on |=> !tmr_busy[T_PK]);

    // R4: while blanking runs, a closed switch stays closed
    a_r4_blank_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && drive_q && tmr_busy[T_BLANK]) |=> drive_q);

    // R4: the blanking window ends when its count runs out
    a_r4_blank_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire[T_BLANK] |=> !tmr_busy[T_BLANK]);

    // R5: while the off-time count runs, an open switch stays open
    a_r5_off_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_on && !drive_q && tmr_busy[T_OFF] && !tmr_expire[T_OFF]) |=> !drive_q);

endmodule

// File: tb/ph_reg_ctrl_tb.sv
module ph_reg_ctrl_tb;

    localparam int B = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_on;
    logic [1:0] mode, pk_code, hd_code, off_code;
    logic [2:0] pt_code;
    logic       cmp_hit, us_tick;
    logic       gate_en, thr_peak;
    logic [1:0] thr_sel;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ph_reg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .mode(mode),
        .pk_code(pk_code), .hd_code(hd_code), .off_code(off_code),
        .pt_code(pt_code), .cmp_hit(cmp_hit), .us_tick(us_tick),
        .gate_en(gate_en), .thr_peak(thr_peak), .thr_sel(thr_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    function automatic int off_len(input int oc);
        return 100 * (oc + 1);
    endfunction

    function automatic int pk_len(input int pc);
        return 800 + 400 * pc;
    endfunction

    function automatic int exp_gate(input int m, input int oc, input int k);
        if (m == 0) return 1;
        return ((k % (B + 1 + off_len(oc))) < (B + 1)) ? 1 : 0;
    endfunction

    function automatic int exp_peak(input int m, input int pc, input int k);
        if (m == 2) return (k < B + 1) ? 1 : 0;
        if (m == 3) return (k < pk_len(pc)) ? 1 : 0;
        return 0;
    endfunction

    // raise the command with the comparator held high and check every cycle
    task automatic run_profile(input int m, input int pk, input int hd,
                               input int oc, input int pc, input int len);
        @(negedge clk);
        mode = 2'(m); pk_code = 2'(pk); hd_code = 2'(hd);
        off_code = 2'(oc); pt_code = 3'(pc);
        cmp_hit = 1'b1; us_tick = 1'b1; cmd_on = 1'b1;
        for (int k = 0; k < len; k++) begin
            int ep;
            @(negedge clk);
            ep = exp_peak(m, pc, k);
            chk((m == 0) ? "R2 gate" : "R5 gate", int'(gate_en), exp_gate(m, oc, k));
            chk((m == 0) ? "R2 peak" : (m == 1) ? "R6 peak" :
                (m == 2) ? "R7 peak" : "R8 peak", int'(thr_peak), ep);
            chk("R11 thr_sel", int'(thr_sel), ep ? pk : hd);
        end
    endtask

    task automatic drop_cmd();
        cmd_on = 1'b0;
        #1;
        chk("R3 gate off at once", int'(gate_en), 0);
        @(negedge clk);
        chk("R3 idle peak", int'(thr_peak), 0);
        chk("R3 idle sel", int'(thr_sel), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..R11 run did not finish: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_on = 1'b0; mode = '0; pk_code = '0; hd_code = '0;
        off_code = '0; pt_code = '0; cmp_hit = 1'b0; us_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gate", int'(gate_en), 0);
        chk("R1 peak", int'(thr_peak), 0);
        chk("R1 sel", int'(thr_sel), 0);

        // sweep modes 00..10 over every off-time code
        for (int m = 0; m < 3; m++) begin
            for (int oc = 0; oc < 4; oc++) begin
                run_profile(m, oc, 3 - oc, oc, 0, 2 * (B + 1 + off_len(oc)) + 5);
                drop_cmd();
            end
        end

        // timed peak over every peak-time code
        for (int pc = 0; pc < 8; pc++) begin
            run_profile(3, 3 - (pc % 4), pc % 4, pc % 4, pc,
                        pk_len(pc) + B + 1 + off_len(pc % 4) + 5);
            drop_cmd();
        end

        // R4: hits inside the blanking window are ignored
        @(negedge clk);
        mode = 2'b01; hd_code = 2'b10; off_code = 2'b00;
        cmp_hit = 1'b1; us_tick = 1'b1; cmd_on = 1'b1;
        for (int k = 0; k <= 41; k++) begin
            @(negedge clk);
            chk("R4 blanked hit", int'(gate_en), (k <= 40) ? 1 : 0);
            if (k == B) cmp_hit = 1'b0;
            if (k == 40) cmp_hit = 1'b1;
        end
        drop_cmd();

        // R9: timers stall without ticks
        @(negedge clk);
        mode = 2'b01; cmp_hit = 1'b1; us_tick = 1'b0; cmd_on = 1'b1;
        for (int k = 0; k <= 60 + B; k++) begin
            @(negedge clk);
            chk("R9 no tick", int'(gate_en), (k < 60 + B) ? 1 : 0);
            if (k == 59) us_tick = 1'b1;
        end
        drop_cmd();

        // R10: configuration changes while active have no effect
        @(negedge clk);
        mode = 2'b01; hd_code = 2'b01; pk_code = 2'b11; off_code = 2'b00;
        cmp_hit = 1'b1; us_tick = 1'b1; cmd_on = 1'b1;
        for (int k = 0; k < 2 * (B + 101) + 3; k++) begin
            @(negedge clk);
            chk("R10 gate", int'(gate_en), exp_gate(1, 0, k));
            chk("R10 peak", int'(thr_peak), 0);
            chk("R10 sel", int'(thr_sel), 1);
            if (k == 0) begin
                mode = 2'b10; hd_code = 2'b10; off_code = 2'b11;
            end
        end
        drop_cmd();

        // R3: drop during the off phase, then a fresh start
        run_profile(3, 2, 1, 0, 0, B + 5);
        drop_cmd();
        run_profile(3, 2, 1, 0, 0, pk_len(0) + 5);
        drop_cmd();

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule